// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the purely combinational integer datapath of a 32-bit load/store processor core. Each cycle the core presents two operands, an operation code and a 5-bit shift count. The unit answers in the same cycle with a full-width result, a flag that is high when the result is all zeros, and a signed-overflow flag. The core uses the zero flag for equal/not-equal branch decisions. It uses the overflow flag to decide whether to raise an arithmetic exception, but that exception logic sits outside this unit.

One shared carry-propagate adder serves addition, subtraction and both less-than compares. The signed and unsigned forms of each operation share the adder's output and differ only in how that output is read. A staged barrel shifter handles the three shift kinds. The same path also places a constant in the upper half of the word.

Operation codes on `op_sel`: 0 add (signed), 1 add (unsigned), 2 subtract (signed), 3 subtract (unsigned), 4 and, 5 or, 6 xor, 7 nor, 8 signed less-than, 9 unsigned less-than, 10 shift left logical, 11 shift right logical, 12 shift right arithmetic, 13 load-upper, 14 and 15 unused.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (add) and 2 (subtract a minus b) give the low 32 bits of the two's-complement result. `ovf_flag` is 1 exactly when the true signed result lies outside -2^31..2^31-1.
- R2: Codes 1 and 3 give the same 32-bit result as codes 0 and 2, and `ovf_flag` is always 0 for them.
- R3: Codes 4, 5, 6 and 7 give the bitwise and, or, xor and nor of the two operands across all 32 bits.
- R4: Code 8 gives 1 when `opnd_a` is less than `opnd_b` as two's-complement numbers and 0 otherwise, with bits 31:1 cleared. With a = 0x80000000 and b = 0x7FFFFFFF it gives 1.
- R5: Code 9 gives 1 when `opnd_a` is less than `opnd_b` as unsigned numbers and 0 otherwise, with bits 31:1 cleared. With a = 0x80000000 and b = 0x7FFFFFFF it gives 0.
- R6: Codes 10, 11 and 12 shift `opnd_a` left with zero fill, right with zero fill, and right with copies of bit 31. The shift distance is `shamt` (0 to 31) and `opnd_b` has no effect.
- R7: Code 13 gives `opnd_b[15:0]` in bits 31:16 and zeros in bits 15:0. Bits 31:16 of `opnd_b` have no effect.
- R8: `zero_flag` is 1 exactly when all 32 result bits are 0, for every code.
- R9: Codes 14 and 15 give a result of 0 and `ovf_flag` of 0.
- R10: `ovf_flag` is 0 for every code other than 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand; the value shifted by the shift codes |
| opnd_b | input | 32 | Second operand; its low half is the load-upper constant |
| shamt | input | 5 | Shift distance |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is zero |
| ovf_flag | output | 1 | Signed add/subtract overflow |

## Verification
The adder is driven with operands at the signed limits (0x7FFFFFFF, 0x80000000, -1, 1). These show overflow in both directions, and they show that the unsigned forms keep the same sum while staying silent. The compares use pairs whose sign bits differ, in particular 0x80000000 against 0x7FFFFFFF, so that the signed and unsigned readings of one subtraction give opposite answers. Equal operands are also used, to check the strict less-than. Shifts use the distances 0, 1, 16 and 31 on negative and positive words, with junk in the second operand, which separates the fill rules and tests every shifter stage. Unused codes, load-upper with dirty upper bits, and a long run of random operands checked against a behavioural model cover the remaining rows and the zero flag.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_LUI  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2,
    SH_UPPER = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] low_part;
  logic [1:0]       top_part;
  logic             c_into_msb;

  always_comb begin
    b_eff      = sub ? ~b : b;
    low_part   = {1'b0, a[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]} + {{(WIDTH-1){1'b0}}, sub};
    c_into_msb = low_part[MSB];
    top_part   = {1'b0, a[MSB]} + {1'b0, b_eff[MSB]} + {1'b0, c_into_msb};
    sum        = {top_part[0], low_part[MSB-1:0]};
    carry      = top_part[1];
    ovf        = c_into_msb ^ top_part[1];

    // R1: overflow only with the sign pattern that can produce it
    if (ovf) begin
      a_r1_ovf_sign_rule: assert ((sub ? (a[MSB] != b[MSB]) : (a[MSB] == b[MSB]))
                                  && (sum[MSB] != a[MSB]))
        else $error("a_r1_ovf_sign_rule");
    end
    // R2: unsigned add wraps exactly when the carry leaves the word
    if (!sub) begin
      a_r2_add_carry: assert (carry == (sum < a))
        else $error("a_r2_add_carry");
    end
  end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (op)
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      default: y = a & b;
    endcase
    // R3: nor and or are complements
    if (op == OP_NOR) begin
      a_r3_nor_or: assert ((y & (a | b)) == '0)
        else $error("a_r3_nor_or");
    end
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         a,
  input  logic [WIDTH/2-1:0]       konst,
  input  logic [$clog2(WIDTH)-1:0] amount,
  input  shift_kind_e              kind,
  output logic [WIDTH-1:0]         y
);
  localparam int MSB    = WIDTH - 1;
  localparam int HALF   = WIDTH / 2;
  localparam int STAGES = $clog2(WIDTH);

  logic [WIDTH-1:0] a_rev;
  logic [WIDTH-1:0] stg [STAGES+1];
  logic [WIDTH-1:0] out_rev;
  logic             fill;

  // Left shifts reuse the right-shift stages on a bit-reversed word.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign a_rev[i]   = a[MSB-i];
    assign out_rev[i] = stg[STAGES][MSB-i];
  end

  assign fill   = (kind == SH_RARI) & a[MSB];
  assign stg[0] = (kind == SH_LEFT) ? a_rev : a;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign stg[s+1] = amount[s] ? {{DIST{fill}}, stg[s][MSB:DIST]} : stg[s];
  end

  always_comb begin
    unique case (kind)
      SH_LEFT:  y = out_rev;
      SH_UPPER: y = {konst, {HALF{1'b0}}};
      default:  y = stg[STAGES];
    endcase
    // R6: arithmetic right shift keeps the sign
    if (kind == SH_RARI) begin
      a_r6_sra_sign: assert (y[MSB] == a[MSB])
        else $error("a_r6_sra_sign");
    end
    // R6: logical right shift by a nonzero amount clears the top bit
    if (kind == SH_RLOG && amount != '0) begin
      a_r6_srl_top: assert (y[MSB] == 1'b0)
        else $error("a_r6_srl_top");
    end
    // R7: load-upper leaves the lower half clear
    if (kind == SH_UPPER) begin
      a_r7_upper_low: assert (y[HALF-1:0] == '0)
        else $error("a_r7_upper_low");
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]               op_sel,
  input  logic [WIDTH-1:0]         opnd_a,
  input  logic [WIDTH-1:0]         opnd_b,
  input  logic [$clog2(WIDTH)-1:0] shamt,
  output logic [WIDTH-1:0]         result,
  output logic                     zero_flag,
  output logic                     ovf_flag
);
  localparam int MSB  = WIDTH - 1;
  localparam int HALF = WIDTH / 2;

  alu_op_e          op;
  logic             use_sub;
  logic [WIDTH-1:0] add_y;
  logic             add_c;
  logic             add_v;
  logic [WIDTH-1:0] log_y;
  logic [WIDTH-1:0] sh_y;
  shift_kind_e      sh_kind;
  logic             lt_signed;
  logic             lt_unsigned;

  assign op      = alu_op_e'(op_sel);
  assign use_sub = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

  always_comb begin
    unique case (op)
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      OP_LUI:  sh_kind = SH_UPPER;
      default: sh_kind = SH_LEFT;
    endcase
  end

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(use_sub),
    .sum(add_y), .carry(add_c), .ovf(add_v)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b), .op(op), .y(log_y)
  );

  int_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a(opnd_a), .konst(opnd_b[HALF-1:0]), .amount(shamt),
    .kind(sh_kind), .y(sh_y)
  );

  // a - b: signed less-than from sign corrected by overflow,
  // unsigned less-than from a missing carry (borrow).
  assign lt_signed   = add_y[MSB] ^ add_v;
  assign lt_unsigned = ~add_c;

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = add_y;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result = log_y;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_unsigned};
      OP_SLL, OP_SRL, OP_SRA, OP_LUI:   result = sh_y;
      default: result = '0;
    endcase
    zero_flag = ~|result;
    ovf_flag  = add_v & ((op == OP_ADD) || (op == OP_SUB));

    // R4: with differing signs the negative operand is the smaller
    if (op == OP_SLT && opnd_a[MSB] != opnd_b[MSB]) begin
      a_r4_slt_sign: assert (result == {{(WIDTH-1){1'b0}}, opnd_a[MSB]})
        else $error("a_r4_slt_sign");
    end
    // R5: with differing top bits the operand with top bit clear is smaller
    if (op == OP_SLTU && opnd_a[MSB] != opnd_b[MSB]) begin
      a_r5_sltu_msb: assert (result == {{(WIDTH-1){1'b0}}, opnd_b[MSB]})
        else $error("a_r5_sltu_msb");
    end
    // R9: unused codes drive nothing
    if (op == OP_RSV0 || op == OP_RSV1) begin
      a_r9_unused_quiet: assert (result == '0 && !ovf_flag)
        else $error("a_r9_unused_quiet");
    end
    // R8: compare results of equal operands are zero
    if ((op == OP_SLT || op == OP_SLTU) && opnd_a == opnd_b) begin
      a_r8_equal_zero: assert (zero_flag)
        else $error("a_r8_equal_zero");
    end
  end
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        zero_flag, ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu uut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
    .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                input logic [31:0] b, input logic [4:0] sh,
                                output logic [31:0] r, output logic v);
    longint sa, sb, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    v  = 1'b0;
    case (op)
      4'd0:  begin t = sa + sb; r = a + b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd1:  r = a + b;
      4'd2:  begin t = sa - sb; r = a - b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd3:  r = a - b;
      4'd4:  r = a & b;
      4'd5:  r = a | b;
      4'd6:  r = a ^ b;
      4'd7:  r = ~(a | b);
      4'd8:  r = (sa < sb) ? 32'd1 : 32'd0;
      4'd9:  r = (a < b) ? 32'd1 : 32'd0;
      4'd10: r = a << sh;
      4'd11: r = a >> sh;
      4'd12: r = $unsigned($signed(a) >>> sh);
      4'd13: r = {b[15:0], 16'h0000};
      default: r = 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] er;
    logic        ev;
    @(posedge clk);
    #1;
    op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
    #(CLK_PERIOD/2 - 2);
    model(op, a, b, sh, er, ev);
    check(tag, "result", result, er);
    check(tag, "ovf", {31'b0, ovf_flag}, {31'b0, ev});
    check("R8", "zero", {31'b0, zero_flag}, {31'b0, (er == 32'h0)});
  endtask

  task automatic t_idle;
    apply("R8", 4'd0, 32'h0, 32'h0, 5'd0);
    check("R8", "idle zero high", {31'b0, zero_flag}, 32'd1);
  endtask

  task automatic t_signed_arith; // R1
    apply("R1", 4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0);
    check("R1", "pos overflow", {31'b0, ovf_flag}, 32'd1);
    apply("R1", 4'd0, 32'h80000000, 32'h80000000, 5'd0);
    apply("R1", 4'd0, 32'hFFFFFFFF, 32'h00000001, 5'd0);
    apply("R1", 4'd2, 32'h80000000, 32'h00000001, 5'd0);
    check("R1", "neg overflow", {31'b0, ovf_flag}, 32'd1);
    apply("R1", 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0);
    apply("R1", 4'd2, 32'h00000005, 32'h00000007, 5'd0);
  endtask

  task automatic t_unsigned_arith; // R2, R10
    apply("R2", 4'd1, 32'h7FFFFFFF, 32'h00000001, 5'd0);
    check("R2", "addu no ovf", {31'b0, ovf_flag}, 32'd0);
    apply("R2", 4'd3, 32'h80000000, 32'h00000001, 5'd0);
    check("R10", "subu no ovf", {31'b0, ovf_flag}, 32'd0);
    apply("R2", 4'd1, 32'hFFFFFFFF, 32'h00000002, 5'd0);
  endtask

  task automatic t_logic; // R3
    for (int op = 4; op < 8; op++) begin
      apply("R3", 4'(op), 32'hF0F0A5A5, 32'h0FF05A5A, 5'd0);
      apply("R3", 4'(op), 32'hFFFFFFFF, 32'h00000000, 5'd0);
    end
  endtask

  task automatic t_compare; // R4, R5
    apply("R4", 4'd8, 32'h80000000, 32'h7FFFFFFF, 5'd0);
    check("R4", "min lt max signed", result, 32'd1);
    apply("R5", 4'd9, 32'h80000000, 32'h7FFFFFFF, 5'd0);
    check("R5", "min lt max unsigned", result, 32'd0);
    apply("R4", 4'd8, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0);
    apply("R4", 4'd8, 32'h7FFFFFFF, 32'h80000000, 5'd0);
    apply("R5", 4'd9, 32'h00000003, 32'hFFFFFFFF, 5'd0);
    apply("R5", 4'd9, 32'h12345678, 32'h12345678, 5'd0);
  endtask

  task automatic t_shift; // R6
    for (int op = 10; op < 13; op++) begin
      apply("R6", 4'(op), 32'h80000001, 32'hDEADBEEF, 5'd0);
      apply("R6", 4'(op), 32'h80000001, 32'hDEADBEEF, 5'd1);
      apply("R6", 4'(op), 32'hC3A50F96, 32'h12345678, 5'd16);
      apply("R6", 4'(op), 32'h80000000, 32'hFFFFFFFF, 5'd31);
      apply("R6", 4'(op), 32'h40000000, 32'h00000000, 5'd31);
    end
    apply("R6", 4'd12, 32'h80000000, 32'h0, 5'd31);
    check("R6", "sra fills ones", result, 32'hFFFFFFFF);
  endtask

  task automatic t_upper; // R7
    apply("R7", 4'd13, 32'h55555555, 32'hFFFF1234, 5'd7);
    check("R7", "upper placement", result, 32'h12340000);
    apply("R7", 4'd13, 32'hFFFFFFFF, 32'hABCD0000, 5'd0);
  endtask

  task automatic t_unused; // R9
    apply("R9", 4'd14, 32'h7FFFFFFF, 32'h00000001, 5'd3);
    apply("R9", 4'd15, 32'h80000000, 32'h00000001, 5'd9);
    check("R9", "unused zero", {31'b0, zero_flag}, 32'd1);
  endtask

  task automatic t_random; // R1..R10 against model
    for (int n = 0; n < 2000; n++) begin
      apply("R10", 4'($urandom_range(0, 15)), $urandom(), $urandom(), 5'($urandom_range(0, 31)));
    end
  endtask

  initial begin
    op_sel = 4'd0; opnd_a = 32'h0; opnd_b = 32'h0; shamt = 5'd0;
    t_idle();
    t_signed_arith();
    t_unsigned_arith();
    t_logic();
    t_compare();
    t_shift();
    t_upper();
    t_unused();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule